// File: doc/BRIEF.md
# Binary-Test Ensemble Window Classifier

This block scores one candidate image window at a time against a learned object model. Each window has already passed a cheap variance screen upstream. The block reads pixel pairs from an external window buffer and compares the two pixels of each pair. It packs the comparison results into `NUM_CODES` independent codes of `CODE_BITS` bits each. Each code addresses its own table of learned positive and negative counts. From the two counts the block derives a posterior fraction for each code and sums these fractions. The window is rejected when the mean posterior falls below one half.

The pixel offsets of every comparison pair are written through a configuration port. A separate update port feeds back the verdict of a later similarity stage. The caller hands back the codes of the window being learned, and every table bumps either the positive or the negative count at the entry that code selects.

Control is a single state machine with these states:
- `S_IDLE`: waiting, with `win_ready` high.
- `S_FETCH`: issues one pixel read per cycle.
- `S_DRAIN`: consumes the last returned pixel.
- `S_LOOK`: all tables are read in parallel.
- `S_LOAD`: the divider is seeded for one code.
- `S_DIV`: `FRAC_W` divide steps.
- `S_ACC`: the fraction is added to the score.
- `S_DONE`: one-cycle result.

The transitions are:
- IDLE→FETCH on `win_start`.
- FETCH→DRAIN after the last read.
- DRAIN→LOOK.
- LOOK→LOAD.
- LOAD→DIV.
- DIV→ACC after `FRAC_W` steps.
- ACC→LOAD while codes remain, and ACC→DONE after the last code.
- DONE→IDLE.

The deployed setting uses 10 codes of 13 bits. The default parameters shrink each code to 8 bits so that the tables stay small.

Top module: `bte_classifier`

## Requirements
- R1: After reset `win_ready` is 1, `win_done` and `win_accept` are 0, and every table count is zero.
- R2: Pair index j = c*CODE_BITS + k is written with `cfg_sel` = j. Bit k of code c is 1 only when the pixel at the pair's first offset is strictly greater than the pixel at its second offset, so equal pixels give 0. Code c appears on `win_codes[c*CODE_BITS +: CODE_BITS]` and on `upd_codes` in the same position.
- R3: A window accepted by `win_start` causes exactly 2*NUM_CODES*CODE_BITS reads on consecutive cycles, in ascending pair order with the first offset before the second. `pix_data` is taken one cycle after its `pix_rd`.
- R4: The posterior of a code with counts p and n is floor(256*p/(p+n)), capped at 255, and is 0 when p+n is 0.
- R5: `win_score` is the sum of the NUM_CODES posteriors. `win_accept` is 1 when the score is at least NUM_CODES*128, so an exact mean of one half is accepted.
- R6: `win_done` is a one-cycle pulse. `win_ready` is low from an accepted start until after that pulse, and a `win_start` seen while not ready is ignored.
- R7: An `upd_valid` cycle increments, in every table c, the positive count (`upd_match`=1) or the negative count (`upd_match`=0) at entry code c of `upd_codes`.
- R8: Counts saturate at 2^CNT_W-1 and never wrap.
- R9: An update in the same cycle as the table lookup of a window, to the same entry, is seen by that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one pair's offsets |
| cfg_sel | input | $clog2(NUM_CODES*CODE_BITS) | Pair index c*CODE_BITS+k |
| cfg_first | input | ADDR_W | Offset of the first pixel |
| cfg_second | input | ADDR_W | Offset of the second pixel |
| win_start | input | 1 | Begin scoring the buffered window |
| win_ready | output | 1 | Idle, start accepted |
| pix_rd | output | 1 | Window buffer read strobe |
| pix_addr | output | ADDR_W | Window buffer read offset |
| pix_data | input | PIX_W | Pixel returned one cycle after a read |
| upd_valid | input | 1 | Apply a learning update |
| upd_match | input | 1 | 1 positive, 0 negative |
| upd_codes | input | NUM_CODES*CODE_BITS | Codes of the window being learned |
| win_done | output | 1 | Result valid pulse |
| win_accept | output | 1 | Window passes (valid with done) |
| win_score | output | $clog2(NUM_CODES*(2^FRAC_W-1)+1) | Sum of posteriors |
| win_codes | output | NUM_CODES*CODE_BITS | Codes of the scored window |

## Verification
Some properties are checked on every cycle:
- The done pulse is one cycle wide and the ready line drops after an accepted start.
- The read burst ends only after the final pair's second read.
- A count never decreases under an increment.
- A lookup that collides with an update returns what the table holds afterwards.

Other behaviour can only be shown by the bench's scenarios, because it needs an independent model of the window and the counts:
- The code values produced from real pixels, including equal pixels.
- The exact posterior arithmetic.
- The tie at one half.
- The forwarded lookup changing the score.
- Saturation after hundreds of updates.

// File: rtl/bte_pkg.sv
package bte_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DRAIN,
        S_LOOK,
        S_LOAD,
        S_DIV,
        S_ACC,
        S_DONE
    } bte_state_e;

endpackage

// File: rtl/bte_pair_reader.sv
module bte_pair_reader #(
    parameter int NUM_CODES = 10,
    parameter int CODE_BITS = 8,
    parameter int ADDR_W    = 6,
    parameter int PIX_W     = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        cfg_we,
    input  logic [$clog2(NUM_CODES*CODE_BITS)-1:0]      cfg_sel,
    input  logic [ADDR_W-1:0]                           cfg_first,
    input  logic [ADDR_W-1:0]                           cfg_second,
    input  logic                                        clear,
    input  logic                                        step,
    output logic                                        pix_rd,
    output logic [ADDR_W-1:0]                           pix_addr,
    input  logic [PIX_W-1:0]                            pix_data,
    output logic [NUM_CODES*CODE_BITS-1:0]              codes,
    output logic                                        last_issue
);

    localparam int NP = NUM_CODES * CODE_BITS;
    localparam int SW = $clog2(NP);
    localparam int CW = SW + 1;

    logic [ADDR_W-1:0] off_a [NP];
    logic [ADDR_W-1:0] off_b [NP];
    logic [CW-1:0]     cnt;
    logic [SW-1:0]     pair;
    logic [SW-1:0]     pair_safe;
    logic              dly_valid;
    logic              dly_second;
    logic [SW-1:0]     dly_pair;
    logic [PIX_W-1:0]  hold;
    logic [NP-1:0]     code_r;

    assign pair       = cnt[CW-1:1];
    assign pair_safe  = (int'(pair) < NP) ? pair : '0;
    assign pix_rd     = step;
    assign pix_addr   = cnt[0] ? off_b[pair_safe] : off_a[pair_safe];
    assign last_issue = step && (cnt == CW'(2*NP-1));
    assign codes      = code_r;

    // offset table written from the configuration port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                off_a[i] <= '0;
                off_b[i] <= '0;
            end
        end else if (cfg_we && (int'(cfg_sel) < NP)) begin
            off_a[cfg_sel] <= cfg_first;
            off_b[cfg_sel] <= cfg_second;
        end
    end

    // read sequencing, one pixel per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            dly_valid  <= 1'b0;
            dly_second <= 1'b0;
            dly_pair   <= '0;
        end else begin
            if (clear)
                cnt <= '0;
            else if (step)
                cnt <= cnt + 1'b1;
            dly_valid  <= step;
            dly_second <= cnt[0];
            dly_pair   <= pair_safe;
        end
    end

    // comparison of the returned pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= '0;
            code_r <= '0;
        end else if (dly_valid) begin
            if (!dly_second)
                hold <= pix_data;
            else
                code_r[dly_pair] <= (hold > pix_data);
        end
    end

endmodule

// File: rtl/bte_count_table.sv
module bte_count_table #(
    parameter int CODE_BITS = 8,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_en,
    input  logic [CODE_BITS-1:0] lk_addr,
    input  logic                 up_en,
    input  logic                 up_match,
    input  logic [CODE_BITS-1:0] up_addr,
    output logic [CNT_W-1:0]     lk_pos,
    output logic [CNT_W-1:0]     lk_neg
);

    localparam int DEPTH = 1 << CODE_BITS;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] pos_mem [DEPTH];
    logic [CNT_W-1:0] neg_mem [DEPTH];
    logic [CNT_W-1:0] pos_now, neg_now, pos_inc, neg_inc;
    logic             hit;

    assign pos_now = pos_mem[up_addr];
    assign neg_now = neg_mem[up_addr];
    assign pos_inc = (pos_now == CMAX) ? pos_now : pos_now + 1'b1;
    assign neg_inc = (neg_now == CMAX) ? neg_now : neg_now + 1'b1;
    assign hit     = up_en && (up_addr == lk_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pos_mem[i] <= '0;
                neg_mem[i] <= '0;
            end
            lk_pos <= '0;
            lk_neg <= '0;
        end else begin
            if (up_en) begin
                if (up_match)
                    pos_mem[up_addr] <= pos_inc;
                else
                    neg_mem[up_addr] <= neg_inc;
            end
            if (lk_en) begin
                lk_pos <= (hit && up_match)  ? pos_inc : pos_mem[lk_addr];
                lk_neg <= (hit && !up_match) ? neg_inc : neg_mem[lk_addr];
            end
        end
    end

    // R9: a colliding lookup returns the value the table holds after the write
    p_fwd_same_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && up_en && (lk_addr == up_addr)) |=>
        ((lk_pos == pos_mem[$past(lk_addr)]) && (lk_neg == neg_mem[$past(lk_addr)])));

    // R8: a positive increment never lowers the count
    p_no_wrap_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && up_match) |=> (pos_mem[$past(up_addr)] >= $past(pos_now)));

    // R8: a negative increment never lowers the count
    p_no_wrap_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !up_match) |=> (neg_mem[$past(up_addr)] >= $past(neg_now)));

endmodule

// File: rtl/bte_post_div.sv
module bte_post_div #(
    parameter int CNT_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [CNT_W-1:0]  p_in,
    input  logic [CNT_W-1:0]  n_in,
    output logic [FRAC_W-1:0] frac
);

    localparam int DW = CNT_W + 1;
    localparam int RW = CNT_W + 2;

    logic [DW-1:0]     den;
    logic [RW-1:0]     rem;
    logic [RW-1:0]     r2;
    logic [FRAC_W-1:0] q;
    logic              ge;

    assign r2   = {rem[RW-2:0], 1'b0};
    assign ge   = (r2 >= {1'b0, den});
    assign frac = (den == '0) ? '0 : q;

    // restoring division, one quotient bit per step; p == p+n yields all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den <= '0;
            rem <= '0;
            q   <= '0;
        end else if (load) begin
            den <= {1'b0, p_in} + {1'b0, n_in};
            rem <= {2'b00, p_in};
            q   <= '0;
        end else if (step) begin
            rem <= ge ? (r2 - {1'b0, den}) : r2;
            q   <= {q[FRAC_W-2:0], ge};
        end
    end

    // R4: the partial remainder never exceeds the denominator
    p_rem_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load || step) |-> (rem <= {1'b0, den}));

endmodule

// File: rtl/bte_classifier.sv
module bte_classifier #(
    parameter int NUM_CODES = 10,
    parameter int CODE_BITS = 8,
    parameter int ADDR_W    = 6,
    parameter int PIX_W     = 8,
    parameter int CNT_W     = 8,
    parameter int FRAC_W    = 8
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                cfg_we,
    input  logic [$clog2(NUM_CODES*CODE_BITS)-1:0]              cfg_sel,
    input  logic [ADDR_W-1:0]                                   cfg_first,
    input  logic [ADDR_W-1:0]                                   cfg_second,
    input  logic                                                win_start,
    output logic                                                win_ready,
    output logic                                                pix_rd,
    output logic [ADDR_W-1:0]                                   pix_addr,
    input  logic [PIX_W-1:0]                                    pix_data,
    input  logic                                                upd_valid,
    input  logic                                                upd_match,
    input  logic [NUM_CODES*CODE_BITS-1:0]                      upd_codes,
    output logic                                                win_done,
    output logic                                                win_accept,
    output logic [$clog2(NUM_CODES*((1<<FRAC_W)-1)+1)-1:0]      win_score,
    output logic [NUM_CODES*CODE_BITS-1:0]                      win_codes
);

    import bte_pkg::*;

    localparam int NP     = NUM_CODES * CODE_BITS;
    localparam int SUM_W  = $clog2(NUM_CODES*((1<<FRAC_W)-1)+1);
    localparam int THRESH = NUM_CODES * (1 << (FRAC_W-1));
    localparam int CI_W   = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1;
    localparam int ST_W   = (FRAC_W > 1) ? $clog2(FRAC_W) : 1;

    bte_state_e        state, state_nx;
    logic [CI_W-1:0]   code_idx;
    logic [ST_W-1:0]   step_cnt;
    logic [SUM_W-1:0]  sum;
    logic              accepted;
    logic              step;
    logic              last_issue;
    logic [NP-1:0]     codes;
    logic [CNT_W-1:0]  tp [NUM_CODES];
    logic [CNT_W-1:0]  tn [NUM_CODES];
    logic [FRAC_W-1:0] frac;

    assign accepted = (state == S_IDLE) && win_start;
    assign step     = (state == S_FETCH);

    bte_pair_reader #(
        .NUM_CODES (NUM_CODES),
        .CODE_BITS (CODE_BITS),
        .ADDR_W    (ADDR_W),
        .PIX_W     (PIX_W)
    ) i_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_first  (cfg_first),
        .cfg_second (cfg_second),
        .clear      (accepted),
        .step       (step),
        .pix_rd     (pix_rd),
        .pix_addr   (pix_addr),
        .pix_data   (pix_data),
        .codes      (codes),
        .last_issue (last_issue)
    );

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_table
        bte_count_table #(
            .CODE_BITS (CODE_BITS),
            .CNT_W     (CNT_W)
        ) i_table (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_en    (state == S_LOOK),
            .lk_addr  (codes[g*CODE_BITS +: CODE_BITS]),
            .up_en    (upd_valid),
            .up_match (upd_match),
            .up_addr  (upd_codes[g*CODE_BITS +: CODE_BITS]),
            .lk_pos   (tp[g]),
            .lk_neg   (tn[g])
        );
    end

    bte_post_div #(
        .CNT_W  (CNT_W),
        .FRAC_W (FRAC_W)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == S_LOAD),
        .step  (state == S_DIV),
        .p_in  (tp[code_idx]),
        .n_in  (tn[code_idx]),
        .frac  (frac)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (win_start) state_nx = S_FETCH;
            S_FETCH: if (last_issue) state_nx = S_DRAIN;
            S_DRAIN: state_nx = S_LOOK;
            S_LOOK:  state_nx = S_LOAD;
            S_LOAD:  state_nx = S_DIV;
            S_DIV:   if (step_cnt == ST_W'(FRAC_W-1)) state_nx = S_ACC;
            S_ACC:   state_nx = (code_idx == CI_W'(NUM_CODES-1)) ? S_DONE : S_LOAD;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // datapath counters and running score
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_idx <= '0;
            step_cnt <= '0;
            sum      <= '0;
        end else begin
            if (accepted) begin
                code_idx <= '0;
                sum      <= '0;
            end
            if (state == S_LOAD)
                step_cnt <= '0;
            else if (state == S_DIV)
                step_cnt <= step_cnt + 1'b1;
            if (state == S_ACC) begin
                sum <= sum + SUM_W'(frac);
                if (code_idx != CI_W'(NUM_CODES-1))
                    code_idx <= code_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        win_ready  = (state == S_IDLE);
        win_done   = (state == S_DONE);
        win_accept = (state == S_DONE) && (sum >= SUM_W'(THRESH));
        win_score  = sum;
        win_codes  = codes;
    end

    // R6: the result pulse lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    // R6: an accepted start makes the block busy
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start && win_ready) |=> !win_ready);

    // R3: the read burst stops only after its final read
    p_burst_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pix_rd) |-> $past(last_issue));

    // R5: the score never exceeds the all-maximum sum
    p_score_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (int'(win_score) <= NUM_CODES*((1<<FRAC_W)-1)));

endmodule

// File: tb/test_bte_classifier.sv
`timescale 1ns/1ps
module test_bte_classifier;

    localparam int N     = 10;
    localparam int B     = 8;
    localparam int AW    = 6;
    localparam int NP    = N * B;
    localparam int TOTAL = 2 * NP;
    localparam int SUMW  = $clog2(N*255+1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [6:0]      cfg_sel = '0;
    logic [AW-1:0]   cfg_first = '0, cfg_second = '0;
    logic            win_start = 1'b0;
    logic            win_ready;
    logic            pix_rd;
    logic [AW-1:0]   pix_addr;
    logic [7:0]      pix_data = '0;
    logic            upd_valid = 1'b0, upd_match = 1'b0;
    logic [NP-1:0]   upd_codes = '0;
    logic            win_done, win_accept;
    logic [SUMW-1:0] win_score;
    logic [NP-1:0]   win_codes;

    int n_checks = 0, n_fail = 0;
    int pm [N][256];
    int nm [N][256];
    logic [7:0] wmem [64];
    int rd_log [TOTAL+8];
    int rd_n = 0, cyc = 0, first_cyc = 0, last_cyc = 0, done_n = 0;

    always #2.5 clk = ~clk;

    bte_classifier #(.NUM_CODES(N), .CODE_BITS(B), .ADDR_W(AW), .PIX_W(8),
                     .CNT_W(8), .FRAC_W(8)) i_bte_classifier (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_first(cfg_first), .cfg_second(cfg_second), .win_start(win_start),
        .win_ready(win_ready), .pix_rd(pix_rd), .pix_addr(pix_addr),
        .pix_data(pix_data), .upd_valid(upd_valid), .upd_match(upd_match),
        .upd_codes(upd_codes), .win_done(win_done), .win_accept(win_accept),
        .win_score(win_score), .win_codes(win_codes));

    // window buffer with one cycle read latency, plus read and done monitors
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (pix_rd) begin
            pix_data <= wmem[pix_addr];
            if (rd_n == 0) first_cyc = cyc;
            last_cyc = cyc;
            if (rd_n < TOTAL + 8) rd_log[rd_n] = int'(pix_addr);
            rd_n = rd_n + 1;
        end
        if (win_done) done_n = done_n + 1;
    end

    function automatic int off_a(int j); return (j*7 + 3) % 64; endfunction
    function automatic int off_b(int j); return (j*13 + 5) % 64; endfunction

    function automatic int post(int p, int n);
        if (p + n == 0) return 0;
        if ((256*p)/(p+n) > 255) return 255;
        return (256*p)/(p+n);
    endfunction

    function automatic logic [NP-1:0] exp_codes();
        logic [NP-1:0] v;
        for (int j = 0; j < NP; j++) v[j] = (wmem[off_a(j)] > wmem[off_b(j)]);
        return v;
    endfunction

    function automatic int exp_score(logic [NP-1:0] cv);
        int s = 0;
        for (int c = 0; c < N; c++) begin
            int e = int'(cv[c*B +: B]);
            s += post(pm[c][e], nm[c][e]);
        end
        return s;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_upd(logic [NP-1:0] cv, bit m);
        for (int c = 0; c < N; c++) begin
            int e = int'(cv[c*B +: B]);
            if (m) begin if (pm[c][e] < 255) pm[c][e]++; end
            else   begin if (nm[c][e] < 255) nm[c][e]++; end
        end
    endtask

    task automatic do_update(logic [NP-1:0] cv, bit m);
        @(negedge clk);
        upd_valid = 1'b1; upd_match = m; upd_codes = cv;
        @(negedge clk);
        upd_valid = 1'b0;
        model_upd(cv, m);
    endtask

    task automatic fill(int kind);
        logic [7:0] l = 8'h5a;
        for (int i = 0; i < 64; i++) begin
            if (kind == 0) wmem[i] = 8'd50;
            else if (kind == 1) wmem[i] = 8'(i*3);
            else begin
                l = {l[6:0], l[7]^l[5]^l[4]^l[3]};
                wmem[i] = l;
            end
        end
    endtask

    // run one window; optionally inject an update into its lookup cycle
    task automatic run_window(bit fwd, bit fm, string tag);
        logic [NP-1:0] ec = exp_codes();
        int es, bad = 0, w = 0;
        rd_n = 0; done_n = 0;
        @(negedge clk); win_start = 1'b1;
        @(posedge clk);
        @(negedge clk); win_start = 1'b0;
        if (fwd) begin
            repeat (TOTAL + 1) @(posedge clk);
            @(negedge clk); upd_valid = 1'b1; upd_match = fm; upd_codes = ec;
            @(negedge clk); upd_valid = 1'b0;
            model_upd(ec, fm);
        end
        while (!win_done && w < 3000) begin @(negedge clk); w++; end
        es = exp_score(ec);
        chk(win_done == 1'b1, {tag, " R6 done seen"}, win_done, 1);
        for (int c = 0; c < N; c++)
            chk(win_codes[c*B +: B] == ec[c*B +: B], {tag, " R2 code"},
                win_codes[c*B +: B], ec[c*B +: B]);
        chk(int'(win_score) == es, {tag, " R4 R5 score"}, win_score, es);
        chk(win_accept == (es >= N*128), {tag, " R5 accept"}, win_accept, es >= N*128);
        chk(rd_n == TOTAL, {tag, " R3 read count"}, rd_n, TOTAL);
        chk(last_cyc - first_cyc + 1 == TOTAL, {tag, " R3 contiguous"},
            last_cyc - first_cyc + 1, TOTAL);
        for (int i = 0; i < TOTAL; i++)
            if (rd_log[i] != ((i % 2) ? off_b(i/2) : off_a(i/2))) bad++;
        chk(bad == 0, {tag, " R3 read order"}, bad, 0);
        @(negedge clk);
        chk(win_done == 1'b0 && win_ready == 1'b1, {tag, " R6 pulse width"}, win_done, 0);
    endtask

    task automatic t_reset();
        chk(win_ready == 1'b1, "R1 ready", win_ready, 1);
        chk(win_done == 1'b0, "R1 done", win_done, 0);
        chk(win_accept == 1'b0, "R1 accept", win_accept, 0);
    endtask

    task automatic t_config();
        for (int j = 0; j < NP; j++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_sel = 7'(j);
            cfg_first = AW'(off_a(j)); cfg_second = AW'(off_b(j));
        end
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // R9: forwarded update on an all-equal window (all codes zero, R2)
    task automatic t_forward();
        fill(0);
        run_window(1'b1, 1'b1, "fwd R9");
    endtask

    // R1 R7 R4 R5: fresh entries, then tie, below half, above half
    task automatic t_learn();
        logic [NP-1:0] ec;
        fill(1);
        ec = exp_codes();
        run_window(1'b0, 1'b0, "ramp R1");
        do_update(ec, 1'b1);
        do_update(ec, 1'b0);
        run_window(1'b0, 1'b0, "tie R5");
        do_update(ec, 1'b0);
        run_window(1'b0, 1'b0, "below R7");
        do_update(ec, 1'b1);
        do_update(ec, 1'b1);
        run_window(1'b0, 1'b0, "above R4");
    endtask

    // R8: saturation of the positive count
    task automatic t_saturate();
        logic [NP-1:0] ec;
        fill(2);
        ec = exp_codes();
        for (int i = 0; i < 300; i++) do_update(ec, 1'b1);
        do_update(ec, 1'b0);
        run_window(1'b0, 1'b0, "sat R8");
    endtask

    // R6: start while busy is ignored
    task automatic t_busy();
        logic [NP-1:0] ec;
        int w = 0, es;
        fill(1);
        ec = exp_codes();
        rd_n = 0; done_n = 0;
        @(negedge clk); win_start = 1'b1;
        @(negedge clk); win_start = 1'b0;
        repeat (20) @(negedge clk);
        chk(win_ready == 1'b0, "R6 busy not ready", win_ready, 0);
        win_start = 1'b1;
        @(negedge clk); win_start = 1'b0;
        while (!win_done && w < 3000) begin @(negedge clk); w++; end
        es = exp_score(ec);
        chk(int'(win_score) == es, "R6 score after ignored start", win_score, es);
        repeat (10) @(negedge clk);
        chk(done_n == 1, "R6 single done", done_n, 1);
        chk(rd_n == TOTAL, "R6 no second burst", rd_n, TOTAL);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++)
            for (int e = 0; e < 256; e++) begin pm[c][e] = 0; nm[c][e] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_forward();
        t_learn();
        t_saturate();
        t_busy();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule